// File: doc/BRIEF.md
# Polled NVM Word Fetch Register

This block puts one host-visible 32-bit register in front of a non-volatile memory word port. Software starts a fetch by writing a word address into the register's address field with the start bit set. The engine then issues a single request to the memory side and waits, for as long as it takes, for the memory to return the word. When the word arrives, the engine stores it in the upper half of the same register and raises a done flag. Software polls that flag and shifts the data down out of the register.

Each write with the start bit fetches one word. To read several words, software issues one start per address and steps the address each time. It stops polling after a fixed budget of polls and treats a missing done flag as an error. The memory side uses a request pulse that carries the address and a valid strobe that carries the data, with any latency of one cycle or more.

Register layout: bit 0 is start on a write and reads back as busy. Bit 1 is done. Bits 15:2 hold the word address. Bits 31:16 hold the fetched data.

Top module: `nvmrd_engine`

## Requirements
- R1: After reset the register reads as all zeros (not busy, not done, address 0, data 0) and `nvm_req` is low.
- R2: A host write with bit 0 set, accepted while idle, raises `nvm_req` for exactly one cycle, in the cycle after the write. During that cycle `nvm_addr` equals bits 15:2 of the written value.
- R3: From the cycle after an accepted start until the word arrives, done (bit 1) reads 0.
- R4: When `nvm_valid` is high while a fetch is waiting, the next cycle shows done = 1, busy = 0, and bits 31:16 equal to the `nvm_rdata` value that was presented.
- R5: A host write with bit 0 set while busy is ignored. The address field and the outstanding fetch are unchanged, no second request is issued, and the result belongs to the first address.
- R6: A host write with bit 0 clear has no effect on any field of the register.
- R7: `nvm_valid` while no fetch is waiting is ignored. The data field and done are unchanged.
- R8: Bits 15:2 read back the address of the most recently accepted start.
- R9: Bit 0 reads 1 from the cycle after an accepted start until the cycle the word is captured. Busy and done are never both 1.
- R10: The data field keeps the previous word after a new start, until the new word is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 32 | Host write value (start bit 0, address bits 15:2) |
| host_rdata | output | 32 | Register read value {data, address, done, busy} |
| nvm_req | output | 1 | One-cycle fetch request to the memory side |
| nvm_addr | output | 14 | Word address of the fetch |
| nvm_valid | input | 1 | Memory data strobe |
| nvm_rdata | input | 16 | Memory word returned with the strobe |

## Verification
A wrong state in the fetch sequencer shows on the very next cycle as a busy bit that disagrees with the reference, or as a request pulse that is missing, doubled or stretched. A wrong capture path shows within one cycle of the valid strobe, either as a done flag that never rises or as wrong data in the upper field. The bench keeps a behavioural model of the register and compares every field on every clock, so any of these faults is reported in the cycle it first appears. Ignored writes and stray strobes are tested by reading the register back right after the stimulus.

// File: rtl/nvmrd_pkg.sv
package nvmrd_pkg;
   // Host register bit positions; software and the read-back decode rely on them
   localparam int START_BIT = 0;
   localparam int DONE_BIT  = 1;
   localparam int ADDR_LSB  = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/nvmrd_decode.sv
module nvmrd_decode
   import nvmrd_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int ADDR_W = 14
) (
   input  logic              host_wr,
   input  logic [REG_W-1:0]  host_wdata,
   input  logic              busy,
   output logic              accept,
   output logic [ADDR_W-1:0] addr_new
);
   localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;

   logic unused_wbits;
   assign unused_wbits = ^{host_wdata[DONE_BIT], host_wdata[REG_W-1:ADDR_MSB+1]};

   // R5 R6: only a start written while idle is taken
   assign accept   = host_wr & host_wdata[START_BIT] & ~busy;
   assign addr_new = host_wdata[ADDR_MSB:ADDR_LSB];
endmodule

// File: rtl/nvmrd_ctrl.sv
module nvmrd_ctrl
   import nvmrd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic nvm_valid,
   output logic busy,
   output logic nvm_req,
   output logic capture
);
   fetch_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_ISSUE;
         ST_ISSUE: state_d = ST_WAIT;
         ST_WAIT:  if (nvm_valid) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy    = (state_q != ST_IDLE);
   assign nvm_req = (state_q == ST_ISSUE);
   assign capture = (state_q == ST_WAIT) & nvm_valid;

   // R2
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nvm_req |=> !nvm_req);
   // R2
   req_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> nvm_req);
   // R9
   busy_until_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !capture) |=> busy);
endmodule

// File: rtl/nvmrd_hold.sv
module nvmrd_hold #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] addr_new,
   input  logic              capture,
   input  logic [DATA_W-1:0] nvm_rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic              done_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         done_q <= 1'b0;
      end else if (accept) begin
         addr_q <= addr_new;   // R8
         done_q <= 1'b0;       // R3, data kept (R10)
      end else if (capture) begin
         data_q <= nvm_rdata;  // R4
         done_q <= 1'b1;
      end
   end

   // R4
   data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (done_q && data_q == $past(nvm_rdata)));
   // R3
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !done_q);
   // R7 R10
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(data_q));
endmodule

// File: rtl/nvmrd_engine.sv
module nvmrd_engine
   import nvmrd_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              nvm_req,
   output logic [13:0]       nvm_addr,
   input  logic              nvm_valid,
   input  logic [15:0]       nvm_rdata
);
   localparam int USED_W = ADDR_LSB + ADDR_W + DATA_W;

   generate
      if (USED_W != REG_W) begin : g_bad_layout
         $error("register fields do not fill REG_W");
      end
      if (REG_W != 32 || ADDR_W != 14 || DATA_W != 16) begin : g_bad_ports
         $error("port widths are fixed at 32/14/16");
      end
   endgenerate

   logic              accept, busy, capture, done_q;
   logic [ADDR_W-1:0] addr_new, addr_q;
   logic [DATA_W-1:0] data_q;

   nvmrd_decode #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_decode (
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .busy       (busy),
      .accept     (accept),
      .addr_new   (addr_new)
   );

   nvmrd_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .nvm_valid (nvm_valid),
      .busy      (busy),
      .nvm_req   (nvm_req),
      .capture   (capture)
   );

   nvmrd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .addr_new  (addr_new),
      .capture   (capture),
      .nvm_rdata (nvm_rdata),
      .addr_q    (addr_q),
      .data_q    (data_q),
      .done_q    (done_q)
   );

   assign host_rdata = {data_q, addr_q, done_q, busy};
   assign nvm_addr   = addr_q;

   // R9
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rdata[START_BIT] && host_rdata[DONE_BIT]));
   // R5
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_wr) |=> $stable(nvm_addr));
   // R6
   nostart_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_wdata[START_BIT] && !busy && !nvm_valid) |=> $stable(host_rdata));
endmodule

// File: tb/test_nvmrd_engine.sv
module test_nvmrd_engine;
   localparam int POLL_LIMIT = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        nvm_req;
   logic [13:0] nvm_addr;
   logic        nvm_valid = 1'b0;
   logic [15:0] nvm_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   nvmrd_engine i_nvmrd_engine (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .nvm_req(nvm_req), .nvm_addr(nvm_addr),
      .nvm_valid(nvm_valid), .nvm_rdata(nvm_rdata));

   function automatic logic [15:0] word_of(input logic [13:0] a);
      return 16'({2'b00, a} * 16'h9E37) ^ 16'h5A5A;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // behavioural reference of the register
   bit          m_busy, m_done, m_req, m_wait;
   logic [13:0] m_addr;
   logic [15:0] m_data;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_req = 0; m_wait = 0; m_addr = 0; m_data = 0;
      end else begin
         if (m_wait && nvm_valid) begin
            m_data = nvm_rdata; m_done = 1; m_busy = 0; m_wait = 0;
         end else if (m_req) begin
            m_req = 0; m_wait = 1;
         end else if (!m_busy && host_wr && host_wdata[0]) begin
            m_busy = 1; m_req = 1; m_done = 0; m_addr = host_wdata[15:2];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R9 busy bit", {31'b0, host_rdata[0]}, {31'b0, m_busy});
         check("R3/R4 done bit", {31'b0, host_rdata[1]}, {31'b0, m_done});
         check("R8 address field", {18'b0, host_rdata[15:2]}, {18'b0, m_addr});
         check("R4/R7/R10 data field", {16'b0, host_rdata[31:16]}, {16'b0, m_data});
         check("R2 request", {31'b0, nvm_req}, {31'b0, m_req});
         if (m_req) check("R2 request address", {18'b0, nvm_addr}, {18'b0, m_addr});
      end
   end

   // memory responder
   int          lat = 1;
   int          cnt = 0;
   bit          mute = 0;
   bit          spur = 0;
   logic [13:0] pend_addr = '0;

   always @(negedge clk) begin
      nvm_valid = 1'b0;
      if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin nvm_valid = 1'b1; nvm_rdata = word_of(pend_addr); end
      end
      if (spur) begin nvm_valid = 1'b1; nvm_rdata = 16'hDEAD; spur = 0; end
      if (nvm_req && !mute) begin pend_addr = nvm_addr; cnt = lat; end
   end

   task automatic do_read(input logic [13:0] a, output logic [15:0] d, output bit ok);
      @(negedge clk); host_wr = 1'b1; host_wdata = {16'h0, a, 2'b01};
      @(negedge clk); host_wr = 1'b0; host_wdata = '0;
      ok = 0; d = '0;
      for (int p = 0; p < POLL_LIMIT; p++) begin
         if (host_rdata[1]) begin ok = 1; d = host_rdata[31:16]; break; end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [31:0] snap;
      bit ok;
      repeat (3) @(negedge clk);
      // R1
      check("R1 reset register", host_rdata, 32'h0);
      check("R1 reset request", {31'b0, nvm_req}, 32'h0);
      rst_n = 1'b1;

      // R4 R8 several latencies and addresses
      lat = 1; do_read(14'h0000, d, ok);
      check("R4 read addr 0", {15'b0, ok, d}, {16'h1, word_of(14'h0000)});
      lat = 3; do_read(14'h0005, d, ok);
      check("R4 read addr 5", {15'b0, ok, d}, {16'h1, word_of(14'h0005)});
      lat = 7; do_read(14'h3FFF, d, ok);
      check("R4 read top addr", {15'b0, ok, d}, {16'h1, word_of(14'h3FFF)});
      check("R8 top address readback", {18'b0, host_rdata[15:2]}, 32'h3FFF);

      // sequential multi-word
      lat = 2;
      for (int i = 0; i < 4; i++) begin
         do_read(14'(14'h0100 + i), d, ok);
         check("R4 sequential word", {15'b0, ok, d}, {16'h1, word_of(14'(14'h0100 + i))});
      end

      // R6 write without start
      snap = host_rdata;
      @(negedge clk); host_wr = 1'b1; host_wdata = {16'hFFFF, 14'h1234, 2'b10};
      @(negedge clk); host_wr = 1'b0; host_wdata = '0;
      @(negedge clk);
      check("R6 no-start write ignored", host_rdata, snap);

      // R5 R10 start while busy
      lat = 20;
      @(negedge clk); host_wr = 1'b1; host_wdata = {16'h0, 14'h0222, 2'b01};
      @(negedge clk); host_wr = 1'b0;
      check("R10 data kept after new start", {16'b0, host_rdata[31:16]}, {16'b0, word_of(14'h0103)});
      check("R3 done cleared", {31'b0, host_rdata[1]}, 32'h0);
      @(negedge clk); host_wr = 1'b1; host_wdata = {16'h0, 14'h0333, 2'b01};
      @(negedge clk); host_wr = 1'b0;
      check("R5 address unchanged", {18'b0, host_rdata[15:2]}, 32'h0222);
      for (int p = 0; p < 40 && !host_rdata[1]; p++) @(negedge clk);
      check("R5 result of first address", {16'b0, host_rdata[31:16]}, {16'b0, word_of(14'h0222)});
      repeat (30) @(negedge clk);
      check("R5 no second fetch", {16'b0, host_rdata[31:16]}, {16'b0, word_of(14'h0222)});

      // R7 stray strobe
      snap = host_rdata;
      @(negedge clk); spur = 1;
      repeat (4) @(negedge clk);
      check("R7 stray valid ignored", host_rdata, snap);

      // host timeout: memory never answers
      mute = 1;
      do_read(14'h0044, d, ok);
      check("poll budget expires", {31'b0, ok}, 32'h0);
      check("R9 still busy", {31'b0, host_rdata[0]}, 32'h1);
      @(negedge clk); rst_n = 1'b0; mute = 0;
      @(negedge clk);
      check("R1 register after reset", host_rdata, 32'h0);
      rst_n = 1'b1;
      lat = 1; do_read(14'h0009, d, ok);
      check("R4 read after recovery", {15'b0, ok, d}, {16'h1, word_of(14'h0009)});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule